// File: doc/BRIEF.md
# Fuse Access Guard

This block sits between a register bus and a paged one-time-programmable fuse array. Software asks for one fuse bit to be blown by writing a bit address to the program-address register, or asks for a whole 32-bit row by writing a row address to the read-address register. Before anything reaches the array, the guard checks the request against several rules. These are a global program enable, a sticky software lock that can only be released by reset, a legal window on one page, rows holding secret keys that may never be read back, and lock fuses stored in page 0 row 43 that protect whole row ranges. A request that passes becomes a single set-bit command or a row-read command on the array port. A request that fails raises an error event instead. Either way the request ends with a one-cycle done event for the interrupt logic.

The sequencer has seven states. ST_IDLE accepts a request and judges it at once. A refusal goes straight to ST_FINISH. A read goes to ST_ROW_FETCH. A program request that needs a lock fuse goes to ST_LOCK_FETCH, and one that needs none goes to ST_PROGRAM. ST_LOCK_FETCH issues a read of the lock row and always moves to ST_LOCK_EVAL. ST_LOCK_EVAL moves to ST_FINISH with an error if the lock fuse is 1, and to ST_PROGRAM otherwise. ST_PROGRAM issues the set-bit command and then moves to ST_FINISH. ST_ROW_FETCH moves to ST_ROW_CAPTURE, which latches the returned row and moves to ST_FINISH. ST_FINISH pulses done, and error when the request was refused, then returns to ST_IDLE. The array returns read data one clock after a read command.

Top module: `fuse_access_guard`

## Requirements
- R1: After reset the outputs busy, evt_done, evt_err, arr_rd_en and arr_set_en are 0. The config (0x04), status (0x08), read-data (0x14) and software-lock (0x44) registers all read 0.
- R2: A fuse address word carries the page in bits 16:13, the row in bits 12:5 and the column in bits 4:0; a read request uses only page and row. The program-address register (0x0C) and the read-address register (0x10) always read 0.
- R3: Every accepted request ends with evt_done high for exactly one cycle. evt_err is high in that same cycle only if the request was refused. The cycle counts after the edge that samples the write are:
  - immediate refusal: done in the first cycle;
  - lock-checked program: read command, wait, then either a set command followed by done, or done with error;
  - unchecked program: set command, then done;
  - allowed read: read command, capture, then done.
- R4: The config register at 0x04 is a plain 32-bit read/write word. While its bit 1 (program enable) is 0, every program request is refused and no set command is issued.
- R5: Bit 0 of the software-lock register at 0x44 becomes 1 when written 1 and stays 1 until reset; writing 0 to it has no effect, and all its other bits read 0. While it is 1, program requests to page 0 rows 44 to 51 are refused.
- R6: On page 0 certain rows are protected by a lock fuse in page 0 row 43: row 4 by column 31, rows 8-11 by column 27, rows 12-19 by column 11, rows 20-27 by column 13, rows 28-35 by column 15, row 37 by column 28, rows 64-71 by column 6, rows 72-79 by column 7 and rows 80-87 by column 8. A program request for such a row first reads row 43 and is refused if that column reads 1.
- R7: On page 2 only addresses from row 129 column 0 up to row 255 column 27 may be programmed; anything outside is refused at once. Inside the window, the request is refused if page 0 row 43 column 16 reads 1.
- R8: Page 1, and the page 0 rows that no rule covers, are programmed without any lock lookup. Program and read requests for page 3 or higher are refused.
- R9: A read of page 0 rows 12 to 35 is refused without touching the array and sets read data (0x14) to 0. Any other allowed read puts the array row into 0x14.
- R10: Status bits 2:0 (0x08) hold one test-bit flag per page. A flag is set by a successful program on that page whose combined value row*32+column is 28 or more, and it stays set until reset.
- R11: A program or read request written while busy is 1 is ignored: it issues no command and changes neither read data nor flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| busy | output | 1 | A request is in flight |
| evt_done | output | 1 | One-cycle request-complete event |
| evt_err | output | 1 | One-cycle request-refused event |
| arr_rd_en | output | 1 | Row read command to the array |
| arr_rd_page | output | 4 | Page of the row read |
| arr_rd_row | output | 8 | Row of the row read |
| arr_rd_data | input | 32 | Row data, valid one cycle after arr_rd_en |
| arr_set_en | output | 1 | Set-bit command to the array |
| arr_set_page | output | 4 | Page of the bit to set |
| arr_set_row | output | 8 | Row of the bit to set |
| arr_set_col | output | 5 | Column of the bit to set |

## Verification
A sequencer that latched the wrong request context or took the wrong branch shows up within one to four cycles. It appears as a command on the array port in the wrong cycle or with the wrong address, or as a done or error event that is missing, extra or misplaced. The bench predicts that pattern from its own fuse image and compares every port on every clock. A wrong verdict therefore surfaces at the first cycle where the real and expected command streams part. Corrupted register state is different: a lost sticky lock or a stale read word stays hidden until a later request or a register read exposes it. The bench therefore reads back the registers after each scenario.

// File: rtl/fuse_guard_pkg.sv
package fuse_guard_pkg;

    // Fuse address field widths; the field order page:row:column is fixed
    localparam int PAGE_W  = 4;
    localparam int ROW_W   = 8;
    localparam int COL_W   = 5;
    localparam int FADDR_W = PAGE_W + ROW_W + COL_W;
    localparam int REG_AW  = 8;

    // Register offsets
    localparam logic [REG_AW-1:0] OFS_CFG      = 8'h04;
    localparam logic [REG_AW-1:0] OFS_STATUS   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_PGM_ADDR = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_RD_ADDR  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_RD_DATA  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_SW_LOCK  = 8'h44;

    localparam int CFG_PGM_EN_BIT = 1;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } fuse_addr_t;

    typedef struct packed {
        logic             refuse;
        logic             need_lock;
        logic [COL_W-1:0] lock_col;
    } verdict_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK_FETCH,
        ST_LOCK_EVAL,
        ST_PROGRAM,
        ST_ROW_FETCH,
        ST_ROW_CAPTURE,
        ST_FINISH
    } guard_state_t;

endpackage

// File: rtl/fuse_guard_regs.sv
module fuse_guard_regs
    import fuse_guard_pkg::*;
#(
    parameter int NUM_PAGES = 3,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              rdata_load,
    input  logic [DATA_W-1:0] rdata_val,
    input  logic              tbit_set,
    input  logic [PAGE_W-1:0] tbit_page,
    output logic              pgm_en,
    output logic              sw_lock,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [DATA_W-1:0]    cfg_q;
    logic                 sw_lock_q;
    logic [DATA_W-1:0]    rdata_q;
    logic [NUM_PAGES-1:0] tbit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            sw_lock_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (bus_we && bus_addr == OFS_CFG) begin
                cfg_q <= bus_wdata;
            end
            // write-once: only a 1 in bit 0 has any effect
            if (bus_we && bus_addr == OFS_SW_LOCK && bus_wdata[0]) begin
                sw_lock_q <= 1'b1;
            end
            if (rdata_load) begin
                rdata_q <= rdata_val;
            end
        end
    end

    // one sticky test-bit flag per page
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_tbit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbit_q[g] <= 1'b0;
            end else if (tbit_set && tbit_page == PAGE_W'(g)) begin
                tbit_q[g] <= 1'b1;
            end
        end
    end

    assign pgm_en  = cfg_q[CFG_PGM_EN_BIT];
    assign sw_lock = sw_lock_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CFG:     bus_rdata = cfg_q;
            OFS_STATUS:  bus_rdata[NUM_PAGES-1:0] = tbit_q;
            OFS_RD_DATA: bus_rdata = rdata_q;
            OFS_SW_LOCK: bus_rdata[0] = sw_lock_q;
            default:     bus_rdata = '0;
        endcase
    end

    // R5: once set, the software lock never drops until reset
    p_sticky_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sw_lock_q |=> sw_lock_q);

    // R10: test-bit flags never clear outside reset
    p_tbit_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tbit_q != '0) |=> ((tbit_q & $past(tbit_q)) == $past(tbit_q)));

endmodule

// File: rtl/fuse_guard_policy.sv
module fuse_guard_policy
    import fuse_guard_pkg::*;
#(
    parameter int NUM_PAGES    = 3,
    parameter int WIN_PAGE     = 2,
    parameter int WIN_LO_ROW   = 129,
    parameter int WIN_LO_COL   = 0,
    parameter int WIN_HI_ROW   = 255,
    parameter int WIN_HI_COL   = 27,
    parameter int WIN_LOCK_COL = 16,
    parameter int SWLOCK_LO    = 44,
    parameter int SWLOCK_HI    = 51,
    parameter int RDBLK_LO     = 12,
    parameter int RDBLK_HI     = 35
) (
    input  fuse_addr_t addr,
    input  logic       is_prog,
    input  logic       pgm_en,
    input  logic       sw_lock,
    output verdict_t   verdict
);

    localparam int WIN_LO = WIN_LO_ROW * (1 << COL_W) + WIN_LO_COL;
    localparam int WIN_HI = WIN_HI_ROW * (1 << COL_W) + WIN_HI_COL;

    // page-0 row to lock-fuse column; top bit flags a protected row
    function automatic logic [COL_W:0] pg0_lock(input logic [ROW_W-1:0] r);
        case (int'(r)) inside
            4:        return {1'b1, COL_W'(31)};
            [8:11]:   return {1'b1, COL_W'(27)};
            [12:19]:  return {1'b1, COL_W'(11)};
            [20:27]:  return {1'b1, COL_W'(13)};
            [28:35]:  return {1'b1, COL_W'(15)};
            37:       return {1'b1, COL_W'(28)};
            [64:71]:  return {1'b1, COL_W'(6)};
            [72:79]:  return {1'b1, COL_W'(7)};
            [80:87]:  return {1'b1, COL_W'(8)};
            default:  return '0;
        endcase
    endfunction

    int row_i;
    int pos_i;
    logic page_bad;

    always_comb begin
        row_i    = int'(addr.row);
        pos_i    = int'({addr.row, addr.col});
        page_bad = int'(addr.page) >= NUM_PAGES;
        verdict  = '0;
        if (page_bad) begin
            verdict.refuse = 1'b1;
        end else if (!is_prog) begin
            verdict.refuse = (addr.page == '0) && row_i >= RDBLK_LO && row_i <= RDBLK_HI;
        end else if (!pgm_en) begin
            verdict.refuse = 1'b1;
        end else if (addr.page == '0) begin
            if (sw_lock && row_i >= SWLOCK_LO && row_i <= SWLOCK_HI) begin
                verdict.refuse = 1'b1;
            end else begin
                {verdict.need_lock, verdict.lock_col} = pg0_lock(addr.row);
            end
        end else if (int'(addr.page) == WIN_PAGE) begin
            if (pos_i < WIN_LO || pos_i > WIN_HI) begin
                verdict.refuse = 1'b1;
            end else begin
                verdict.need_lock = 1'b1;
                verdict.lock_col  = COL_W'(WIN_LOCK_COL);
            end
        end
    end

endmodule

// File: rtl/fuse_guard_seq.sv
module fuse_guard_seq
    import fuse_guard_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LOCK_ROW = 43,
    parameter int TBIT_POS = 28,
    parameter int RDBLK_LO = 12,
    parameter int RDBLK_HI = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_req,
    input  logic              rd_req,
    input  fuse_addr_t        req_addr,
    input  verdict_t          verdict,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic              busy,
    output logic              evt_done,
    output logic              evt_err,
    output logic              arr_rd_en,
    output logic [PAGE_W-1:0] arr_rd_page,
    output logic [ROW_W-1:0]  arr_rd_row,
    output logic              arr_set_en,
    output logic [PAGE_W-1:0] arr_set_page,
    output logic [ROW_W-1:0]  arr_set_row,
    output logic [COL_W-1:0]  arr_set_col,
    output logic              rdata_load,
    output logic [DATA_W-1:0] rdata_val,
    output logic              tbit_set,
    output logic [PAGE_W-1:0] tbit_page
);

    guard_state_t     st_q, st_d;
    fuse_addr_t       addr_q;
    logic             prog_q;
    logic             err_q, err_d;
    logic [COL_W-1:0] lock_col_q;
    logic             accept;

    assign accept = (st_q == ST_IDLE) && (pgm_req || rd_req);

    // state register and latched request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            err_q      <= 1'b0;
            addr_q     <= '0;
            prog_q     <= 1'b0;
            lock_col_q <= '0;
        end else begin
            st_q  <= st_d;
            err_q <= err_d;
            if (accept) begin
                addr_q     <= req_addr;
                prog_q     <= pgm_req;
                lock_col_q <= verdict.lock_col;
            end
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        err_d = err_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    err_d = verdict.refuse;
                    if (verdict.refuse)         st_d = ST_FINISH;
                    else if (rd_req)            st_d = ST_ROW_FETCH;
                    else if (verdict.need_lock) st_d = ST_LOCK_FETCH;
                    else                        st_d = ST_PROGRAM;
                end
            end
            ST_LOCK_FETCH:  st_d = ST_LOCK_EVAL;
            ST_LOCK_EVAL: begin
                if (arr_rd_data[lock_col_q]) begin
                    err_d = 1'b1;
                    st_d  = ST_FINISH;
                end else begin
                    st_d  = ST_PROGRAM;
                end
            end
            ST_PROGRAM:     st_d = ST_FINISH;
            ST_ROW_FETCH:   st_d = ST_ROW_CAPTURE;
            ST_ROW_CAPTURE: st_d = ST_FINISH;
            ST_FINISH:      st_d = ST_IDLE;
            default:        st_d = ST_IDLE;
        endcase
    end

    // outputs, decoded from state only
    always_comb begin
        busy         = (st_q != ST_IDLE);
        arr_rd_en    = (st_q == ST_LOCK_FETCH) || (st_q == ST_ROW_FETCH);
        arr_rd_page  = (st_q == ST_LOCK_FETCH) ? '0 : addr_q.page;
        arr_rd_row   = (st_q == ST_LOCK_FETCH) ? ROW_W'(LOCK_ROW) : addr_q.row;
        arr_set_en   = (st_q == ST_PROGRAM);
        arr_set_page = addr_q.page;
        arr_set_row  = addr_q.row;
        arr_set_col  = addr_q.col;
        evt_done     = (st_q == ST_FINISH);
        evt_err      = (st_q == ST_FINISH) && err_q;
        rdata_load   = (st_q == ST_ROW_CAPTURE) || ((st_q == ST_FINISH) && !prog_q && err_q);
        rdata_val    = (st_q == ST_ROW_CAPTURE) ? arr_rd_data : '0;
        tbit_set     = (st_q == ST_PROGRAM) && (int'({addr_q.row, addr_q.col}) >= TBIT_POS);
        tbit_page    = addr_q.page;
    end

    // R3: an error event only ever comes with a done event
    p_err_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |-> evt_done);

    // R3: done lasts a single cycle
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done);

    // R3: at most one of read command, set command and done per cycle
    p_cmd_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd_en, arr_set_en, evt_done}));

    // R9: secret-key rows of page 0 never reach the array read port
    p_no_secret_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en && arr_rd_page == '0) |->
            !(int'(arr_rd_row) >= RDBLK_LO && int'(arr_rd_row) <= RDBLK_HI));

    // R11: the unit is free again right after a done event
    p_idle_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !busy);

endmodule

// File: rtl/fuse_access_guard.sv
module fuse_access_guard
    import fuse_guard_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_PAGES = 3,
    parameter int LOCK_ROW  = 43,
    parameter int TBIT_POS  = 28,
    parameter int RDBLK_LO  = 12,
    parameter int RDBLK_HI  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              evt_done,
    output logic              evt_err,
    output logic              arr_rd_en,
    output logic [PAGE_W-1:0] arr_rd_page,
    output logic [ROW_W-1:0]  arr_rd_row,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic              arr_set_en,
    output logic [PAGE_W-1:0] arr_set_page,
    output logic [ROW_W-1:0]  arr_set_row,
    output logic [COL_W-1:0]  arr_set_col
);

    logic              pgm_req, rd_req;
    logic              pgm_en, sw_lock;
    logic              rdata_load, tbit_set;
    logic [DATA_W-1:0] rdata_val;
    logic [PAGE_W-1:0] tbit_page;
    fuse_addr_t        req_addr;
    verdict_t          verdict;

    assign pgm_req  = bus_we && (bus_addr == OFS_PGM_ADDR);
    assign rd_req   = bus_we && (bus_addr == OFS_RD_ADDR);
    assign req_addr = fuse_addr_t'(bus_wdata[FADDR_W-1:0]);

    fuse_guard_regs #(
        .NUM_PAGES (NUM_PAGES),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .rdata_load (rdata_load),
        .rdata_val  (rdata_val),
        .tbit_set   (tbit_set),
        .tbit_page  (tbit_page),
        .pgm_en     (pgm_en),
        .sw_lock    (sw_lock),
        .bus_rdata  (bus_rdata)
    );

    fuse_guard_policy #(
        .NUM_PAGES (NUM_PAGES),
        .RDBLK_LO  (RDBLK_LO),
        .RDBLK_HI  (RDBLK_HI)
    ) u_policy (
        .addr    (req_addr),
        .is_prog (pgm_req),
        .pgm_en  (pgm_en),
        .sw_lock (sw_lock),
        .verdict (verdict)
    );

    fuse_guard_seq #(
        .DATA_W   (DATA_W),
        .LOCK_ROW (LOCK_ROW),
        .TBIT_POS (TBIT_POS),
        .RDBLK_LO (RDBLK_LO),
        .RDBLK_HI (RDBLK_HI)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pgm_req      (pgm_req),
        .rd_req       (rd_req),
        .req_addr     (req_addr),
        .verdict      (verdict),
        .arr_rd_data  (arr_rd_data),
        .busy         (busy),
        .evt_done     (evt_done),
        .evt_err      (evt_err),
        .arr_rd_en    (arr_rd_en),
        .arr_rd_page  (arr_rd_page),
        .arr_rd_row   (arr_rd_row),
        .arr_set_en   (arr_set_en),
        .arr_set_page (arr_set_page),
        .arr_set_row  (arr_set_row),
        .arr_set_col  (arr_set_col),
        .rdata_load   (rdata_load),
        .rdata_val    (rdata_val),
        .tbit_set     (tbit_set),
        .tbit_page    (tbit_page)
    );

    // R4: no set command ever leaves while program enable is off
    p_set_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_set_en |-> pgm_en);

endmodule

// File: tb/sim_fuse_access_guard.sv
module sim_fuse_access_guard;
    import fuse_guard_pkg::*;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_we;
    logic [DW-1:0] bus_rdata;
    logic          busy, evt_done, evt_err;
    logic          arr_rd_en, arr_set_en;
    logic [3:0]    arr_rd_page, arr_set_page;
    logic [7:0]    arr_rd_row, arr_set_row;
    logic [4:0]    arr_set_col;
    logic [DW-1:0] arr_rd_data;

    always #2 clk = ~clk;

    fuse_access_guard u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_we (bus_we), .bus_rdata (bus_rdata),
        .busy (busy), .evt_done (evt_done), .evt_err (evt_err),
        .arr_rd_en (arr_rd_en), .arr_rd_page (arr_rd_page), .arr_rd_row (arr_rd_row),
        .arr_rd_data (arr_rd_data),
        .arr_set_en (arr_set_en), .arr_set_page (arr_set_page),
        .arr_set_row (arr_set_row), .arr_set_col (arr_set_col)
    );

    // fuse array stand-in, one-cycle read latency
    logic [DW-1:0] mem   [0:3][0:255];
    logic [DW-1:0] mfuse [0:3][0:255];

    always @(posedge clk) begin
        if (arr_rd_en) arr_rd_data <= mem[arr_rd_page[1:0]][arr_rd_row];
        if (arr_set_en) mem[arr_set_page[1:0]][arr_set_row][arr_set_col] <= 1'b1;
    end

    // reference model state
    typedef struct packed {
        logic busy, rd, set, done, err;
        logic [3:0] page;
        logic [7:0] row;
        logic [4:0] col;
    } exp_t;

    exp_t          expq[$];
    exp_t          ecur;
    logic [DW-1:0] m_cfg   = '0;
    logic          m_lock  = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    logic [2:0]    m_tbits = '0;
    int            chk_n = 0;
    int            err_n = 0;
    string         cur_tag = "R1";

    function automatic exp_t mk(input logic rd, set, done, err, input int p, r, c);
        exp_t e;
        e.busy = 1'b1; e.rd = rd; e.set = set; e.done = done; e.err = err;
        e.page = 4'(p); e.row = 8'(r); e.col = 5'(c);
        return e;
    endfunction

    function automatic int lock_col_of(input int r);
        if (r == 4) return 31;
        if (r == 37) return 28;
        if (r >= 8 && r <= 11) return 27;
        if (r >= 12 && r <= 35) return 11 + 2 * ((r - 12) / 8);
        if (r >= 64 && r <= 87) return 6 + (r - 64) / 8;
        return -1;
    endfunction

    function automatic void model_program(input logic [16:0] a);
        int p, r, c, pos, lk;
        bit refuse;
        p = int'(a[16:13]); r = int'(a[12:5]); c = int'(a[4:0]);
        pos = r * 32 + c; lk = -1; refuse = 0;
        if (!m_cfg[1] || p > 2) refuse = 1;
        else if (p == 0) begin
            if (m_lock && r >= 44 && r <= 51) refuse = 1;
            else lk = lock_col_of(r);
        end else if (p == 2) begin
            if (pos < 129 * 32 || pos > 255 * 32 + 27) refuse = 1;
            else lk = 16;
        end
        if (refuse) begin
            expq.push_back(mk(0, 0, 1, 1, 0, 0, 0));
            return;
        end
        if (lk >= 0) begin
            expq.push_back(mk(1, 0, 0, 0, 0, 43, 0));
            expq.push_back(mk(0, 0, 0, 0, 0, 0, 0));
            if (mfuse[0][43][lk]) begin
                expq.push_back(mk(0, 0, 1, 1, 0, 0, 0));
                return;
            end
        end
        expq.push_back(mk(0, 1, 0, 0, p, r, c));
        expq.push_back(mk(0, 0, 1, 0, 0, 0, 0));
        mfuse[p][r][c] = 1'b1;
        if (pos >= 28) m_tbits[p] = 1'b1;
    endfunction

    function automatic void model_read(input logic [16:0] a);
        int p, r;
        p = int'(a[16:13]); r = int'(a[12:5]);
        if (p > 2 || (p == 0 && r >= 12 && r <= 35)) begin
            expq.push_back(mk(0, 0, 1, 1, 0, 0, 0));
            m_rdata = '0;
        end else begin
            expq.push_back(mk(1, 0, 0, 0, p, r, 0));
            expq.push_back(mk(0, 0, 0, 0, 0, 0, 0));
            expq.push_back(mk(0, 0, 1, 0, 0, 0, 0));
            m_rdata = mfuse[p][r];
        end
    endfunction

    // per-cycle comparison, then model the inputs sampled at the next edge
    always @(negedge clk) begin
        if (rst_n) begin
            ecur = (expq.size() > 0) ? expq.pop_front() : '0;
            chk_n++;
            if (busy !== ecur.busy || arr_rd_en !== ecur.rd || arr_set_en !== ecur.set ||
                evt_done !== ecur.done || evt_err !== ecur.err ||
                (ecur.rd && (arr_rd_page !== ecur.page || arr_rd_row !== ecur.row)) ||
                (ecur.set && ({arr_set_page, arr_set_row, arr_set_col} !== {ecur.page, ecur.row, ecur.col}))) begin
                err_n++;
                $display("FAIL %s cycle: busy/rd/set/done/err=%b%b%b%b%b rd=%0d:%0d set=%0d:%0d:%0d, expected %b%b%b%b%b at %0d:%0d:%0d",
                         cur_tag, busy, arr_rd_en, arr_set_en, evt_done, evt_err,
                         arr_rd_page, arr_rd_row, arr_set_page, arr_set_row, arr_set_col,
                         ecur.busy, ecur.rd, ecur.set, ecur.done, ecur.err, ecur.page, ecur.row, ecur.col);
            end
            if (bus_we) begin
                if (bus_addr == 8'h04) m_cfg = bus_wdata;
                if (bus_addr == 8'h44 && bus_wdata[0]) m_lock = 1'b1;
                if (!ecur.busy && bus_addr == 8'h0C) model_program(bus_wdata[16:0]);
                if (!ecur.busy && bus_addr == 8'h10) model_read(bus_wdata[16:0]);
            end
        end
    end

    function automatic logic [DW-1:0] pa(input int p, r, c);
        return {15'd0, 4'(p), 8'(r), 5'(c)};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    task automatic reg_chk(input logic [7:0] a, input logic [DW-1:0] exp, input string tag);
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk_n++;
        if (bus_rdata !== exp) begin
            err_n++;
            $display("FAIL %s: reg 0x%h read %h expected %h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", chk_n, err_n);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        err_n++;
        $display("FAIL R3 watchdog: run still busy, expected completion");
        summary();
        $finish;
    end

    initial begin
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 256; r++) begin
                mem[p][r]   = (p == 0 && r == 43) ? '0 :
                              ((32'(p) * 32'h0107_0000) + (32'(r) * 32'h0001_0203)) ^ 32'hA5A5_0000;
                mfuse[p][r] = mem[p][r];
            end
        end
        repeat (3) @(negedge clk);
        chk_n++;
        if ({busy, evt_done, evt_err, arr_rd_en, arr_set_en} !== 5'b0) begin
            err_n++;
            $display("FAIL R1: outputs in reset %b expected 00000",
                     {busy, evt_done, evt_err, arr_rd_en, arr_set_en});
        end
        @(posedge clk); #1 rst_n = 1'b1;

        // R1 reset values
        cur_tag = "R1";
        reg_chk(8'h04, '0, "R1");
        reg_chk(8'h08, '0, "R1");
        reg_chk(8'h14, '0, "R1");
        reg_chk(8'h44, '0, "R1");

        // R4 program enable off
        cur_tag = "R4";
        wr(8'h0C, pa(1, 5, 3)); settle();
        wr(8'h0C, pa(0, 9, 1)); settle();
        wr(8'h04, 32'h0000_00F2);
        reg_chk(8'h04, 32'h0000_00F2, "R4");

        // R8 unguarded page-1 program, R9 plain read back
        cur_tag = "R8";
        wr(8'h0C, pa(1, 5, 3)); settle();
        cur_tag = "R9";
        wr(8'h10, pa(1, 5, 0)); settle();
        reg_chk(8'h14, m_rdata, "R9");

        // R2 address registers read 0
        reg_chk(8'h0C, '0, "R2");
        reg_chk(8'h10, '0, "R2");

        // R10 test-bit flags
        cur_tag = "R10";
        wr(8'h0C, pa(1, 0, 29)); settle();
        reg_chk(8'h08, 32'h2, "R10");
        wr(8'h0C, pa(0, 0, 5)); settle();
        reg_chk(8'h08, 32'h2, "R10");
        wr(8'h0C, pa(0, 60, 0)); settle();
        reg_chk(8'h08, 32'h3, "R10");

        // R6 lock fuses in row 43
        cur_tag = "R6";
        wr(8'h0C, pa(0, 12, 0)); settle();
        wr(8'h0C, pa(0, 43, 11)); settle();
        wr(8'h0C, pa(0, 15, 2)); settle();
        wr(8'h0C, pa(0, 43, 31)); settle();
        wr(8'h0C, pa(0, 4, 3)); settle();
        wr(8'h0C, pa(0, 9, 4)); settle();
        wr(8'h0C, pa(0, 70, 1)); settle();
        wr(8'h0C, pa(0, 43, 6)); settle();
        wr(8'h0C, pa(0, 71, 2)); settle();
        wr(8'h10, pa(0, 43, 0)); settle();
        reg_chk(8'h14, m_rdata, "R6");

        // R5 sticky software lock
        cur_tag = "R5";
        wr(8'h0C, pa(0, 45, 0)); settle();
        wr(8'h44, 32'hFFFF_FFFE);
        reg_chk(8'h44, 32'h0, "R5");
        wr(8'h44, 32'h0000_0001);
        reg_chk(8'h44, 32'h1, "R5");
        wr(8'h44, 32'h0);
        reg_chk(8'h44, 32'h1, "R5");
        wr(8'h0C, pa(0, 50, 7)); settle();
        wr(8'h0C, pa(0, 44, 0)); settle();
        wr(8'h0C, pa(0, 52, 1)); settle();

        // R7 page-2 window
        cur_tag = "R7";
        wr(8'h0C, pa(2, 128, 31)); settle();
        wr(8'h0C, pa(2, 129, 0)); settle();
        wr(8'h0C, pa(2, 255, 27)); settle();
        wr(8'h0C, pa(2, 255, 28)); settle();
        reg_chk(8'h08, 32'h7, "R7");
        wr(8'h0C, pa(0, 43, 16)); settle();
        wr(8'h0C, pa(2, 200, 1)); settle();

        // R8 page 3 and above
        cur_tag = "R8";
        wr(8'h0C, pa(3, 1, 1)); settle();
        wr(8'h10, pa(1, 9, 0)); settle();
        wr(8'h10, pa(7, 9, 0)); settle();
        reg_chk(8'h14, 32'h0, "R8");

        // R9 secret rows
        cur_tag = "R9";
        wr(8'h10, pa(0, 36, 0)); settle();
        reg_chk(8'h14, m_rdata, "R9");
        wr(8'h10, pa(0, 20, 0)); settle();
        reg_chk(8'h14, 32'h0, "R9");
        wr(8'h10, pa(0, 11, 0)); settle();
        wr(8'h10, pa(0, 35, 0)); settle();
        reg_chk(8'h14, 32'h0, "R9");
        wr(8'h10, pa(0, 12, 0)); settle();

        // R11 request while busy is dropped
        cur_tag = "R11";
        wr(8'h10, pa(2, 3, 0)); settle();
        wr(8'h0C, pa(1, 7, 2));
        wr(8'h10, pa(1, 9, 0)); settle();
        reg_chk(8'h14, m_rdata, "R11");
        wr(8'h0C, pa(2, 130, 0));
        wr(8'h0C, pa(1, 40, 3)); settle();
        wr(8'h10, pa(1, 40, 0)); settle();
        reg_chk(8'h14, m_rdata, "R11");

        // R3 sequencing was compared every cycle above; close out
        cur_tag = "R3";
        settle();
        chk_n++;
        if (expq.size() != 0) begin
            err_n++;
            $display("FAIL R3: %0d expected events left, expected 0", expq.size());
        end
        summary();
        $finish;
    end

endmodule